// File: doc/BRIEF.md
# Pipelined Signed Array Multiplier

This block multiplies two 8-bit two's-complement operands and returns their exact 16-bit two's-complement product. It is built as a regular carry-save array of full adders that takes one multiplier bit per row. The sign of both operands is handled by inverting selected partial-product bits and injecting two constant ones. No separate correction step is needed. A register level sits after every adder row and after every bit of the final carry-propagate adder. The block therefore accepts a new operand pair on every clock and never stalls.

The surrounding logic raises `inValid` together with the operands in any cycle it wants a product. That pair's result comes out a fixed number of edges later with `outValid` high. Gaps in the input stream pass through the pipeline as gaps in `outValid`. A synchronous reset discards everything in flight. It clears only the valid bits and leaves the data registers alone.

Top module: `signedArrayMult`

## Requirements
- R1: For every one of the 65536 operand pairs, `product` equals the signed product of `opA` and `opB`, where operands are 8-bit two's complement and the product is 16-bit two's complement.
- R2: A pair sampled at a rising edge with `inValid` high appears on `product`, with `outValid` high, right after the 17th rising edge, counting the sampling edge as the first. That is 16 edges after the sampling edge.
- R3: Pairs presented on consecutive cycles are all accepted without stalls. Their results come out on consecutive cycles, in the order the pairs were given.
- R4: `outValid` is high only for results of pairs sampled with `inValid` high. Idle input cycles show up as idle output cycles at the same spacing.
- R5: `rst` is synchronous. It clears every in-flight result, and a pair present while `rst` is high is dropped. `outValid` is low from the first edge with `rst` high until a pair sampled after reset has crossed the pipeline.
- R6: The extreme operands give exact results without overflow: -128 × -128 = +16384 (0x4000), -128 × 127 = -16256, and 127 × 127 = +16129.
- R7: While `outValid` is low, `product` keeps the last result that was delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands on `opA`/`opB` are to be multiplied |
| opA | input | 8 | Multiplicand, two's complement |
| opB | input | 8 | Multiplier, two's complement |
| outValid | output | 1 | `product` holds a new result this cycle |
| product | output | 16 | Signed product, two's complement |

## Verification
Each result is due exactly 16 edges after the edge that sampled its operands. The driver stamps every expected product with that due cycle as it pushes it into the scoreboard. The monitor samples on falling edges and pops an item only when `outValid` is high. It then compares both the value and the cycle number against the stamp, and it flags a result that is missing at its due cycle as well as a valid pulse that nothing was queued for. The full back-to-back sweep of all operand pairs, the spaced corner cases and the reset in mid-stream all rely on that same per-item due cycle.

// File: rtl/samPkg.sv
package samPkg;

  // Partial-product bit of the signed array: the sign row and sign column
  // are inverted, except where they cross.
  function automatic logic ppBit(input logic aBit, input logic bBit,
                                 input int col, input int row, input int w);
    logic flip;
    flip = ((col == w - 1) != (row == w - 1));
    return (aBit & bBit) ^ flip;
  endfunction

  function automatic logic faSum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic faCarry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/samControl.sv
module samControl #(
  parameter int LATENCY = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic [LATENCY-1:0] stageLoad,
  output logic               outValid
);

  logic [LATENCY-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LATENCY-2:0], inValid};
  end

  // Stage s captures when the token in front of it is valid; nothing moves in reset.
  assign stageLoad = rst ? '0 : {vld[LATENCY-2:0], inValid};
  assign outValid  = vld[LATENCY-1];

  // R2: a token enters the pipeline exactly when inValid was sampled high
  assert_token_entry_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld[0] == $past(inValid)));

  // R2: the output flag is the token one stage earlier, delayed one edge
  assert_token_exit_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(vld[LATENCY-2])));

  // R5: an edge taken in reset leaves no result flagged
  assert_reset_clears_R5: assert property (@(posedge clk)
    $past(rst) |-> !outValid);

endmodule

// File: rtl/samDatapath.sv
module samDatapath #(
  parameter int WIDTH   = 8,
  parameter int LATENCY = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LATENCY-1:0]   stageLoad,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  output logic [2*WIDTH-1:0]   product
);
  import samPkg::*;

  localparam int PW   = 2 * WIDTH;
  localparam int CORE = 2 * WIDTH + 1;   // input level + one per row + one per result bit
  localparam int PAD  = LATENCY - CORE;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // Operand copies travelling with their rows
  logic [WIDTH-1:0] aR [WIDTH];
  logic [WIDTH-1:0] bR [WIDTH];

  // Carry-save array: sum, carry and settled low product bits after each row
  logic [WIDTH-1:0] sR  [WIDTH];
  logic [WIDTH-1:0] cR  [WIDTH];
  logic [WIDTH-1:0] lR  [WIDTH];
  logic [WIDTH-1:0] sNx [WIDTH];
  logic [WIDTH-1:0] cNx [WIDTH];
  logic [WIDTH-1:0] lNx [WIDTH];

  // Bit-serial carry-propagate stages
  logic [WIDTH-1:0] psR  [WIDTH];
  logic [WIDTH-1:0] pcR  [WIDTH];
  logic [WIDTH-1:0] hiR  [WIDTH];
  logic [WIDTH-1:0] loR  [WIDTH];
  logic             cyR  [WIDTH];
  logic [WIDTH-1:0] psNx [WIDTH];
  logic [WIDTH-1:0] pcNx [WIDTH];
  logic [WIDTH-1:0] hiNx [WIDTH];
  logic [WIDTH-1:0] loNx [WIDTH];
  logic             cyNx [WIDTH];

  logic [PW-1:0] coreProd;

  // One row of full adders: returns {carries, sums}
  function automatic logic [PW-1:0] csaRow(input logic [WIDTH-1:0] a, input logic bj,
                                           input logic [WIDTH-1:0] s, input logic [WIDTH-1:0] c,
                                           input int row);
    logic [WIDTH-1:0] sumV;
    logic [WIDTH-1:0] carV;
    for (int i = 0; i < WIDTH; i++) begin
      logic pp;
      pp      = ppBit(a[i], bj, i, row, WIDTH);
      sumV[i] = faSum(s[i], c[i], pp);
      carV[i] = faCarry(s[i], c[i], pp);
    end
    return {carV, sumV};
  endfunction

  for (genvar j = 0; j < WIDTH; j++) begin : gRow
    logic [WIDTH-1:0] sIn;
    logic [WIDTH-1:0] cIn;
    logic [WIDTH-1:0] lIn;
    logic [PW-1:0]    step;
    if (j == 0) begin : gFirst
      assign sIn = '0;
      assign cIn = '0;
      assign lIn = '0;
    end else begin : gNext
      assign sIn = sR[j-1];
      assign cIn = cR[j-1];
      assign lIn = lR[j-1];
    end
    assign step = csaRow(aR[j], bR[j][j], sIn, cIn, j);
    // The free top sum slot carries the constant ones at weights WIDTH and 2*WIDTH-1
    assign sNx[j] = {((j == 0) || (j == WIDTH - 1)) ? 1'b1 : 1'b0, step[WIDTH-1:1]};
    assign cNx[j] = step[PW-1:WIDTH];
    assign lNx[j] = lIn | ((step[0] ? ONE : '0) << j);
  end

  for (genvar k = 0; k < WIDTH; k++) begin : gAdd
    logic [WIDTH-1:0] psIn;
    logic [WIDTH-1:0] pcIn;
    logic [WIDTH-1:0] hiIn;
    logic [WIDTH-1:0] loIn;
    logic             cyIn;
    logic             bitK;
    if (k == 0) begin : gFirst
      assign psIn = sR[WIDTH-1];
      assign pcIn = cR[WIDTH-1];
      assign hiIn = '0;
      assign loIn = lR[WIDTH-1];
      assign cyIn = 1'b0;
    end else begin : gNext
      assign psIn = psR[k-1];
      assign pcIn = pcR[k-1];
      assign hiIn = hiR[k-1];
      assign loIn = loR[k-1];
      assign cyIn = cyR[k-1];
    end
    assign bitK     = faSum(psIn[k], pcIn[k], cyIn);
    assign cyNx[k]  = faCarry(psIn[k], pcIn[k], cyIn);
    assign psNx[k]  = psIn;
    assign pcNx[k]  = pcIn;
    assign loNx[k]  = loIn;
    assign hiNx[k]  = hiIn | ((bitK ? ONE : '0) << k);
  end

  always_ff @(posedge clk) begin
    if (stageLoad[0]) begin
      aR[0] <= opA;
      bR[0] <= opB;
    end
    for (int j = 1; j < WIDTH; j++) begin
      if (stageLoad[j]) begin
        aR[j] <= aR[j-1];
        bR[j] <= bR[j-1];
      end
    end
    for (int j = 0; j < WIDTH; j++) begin
      if (stageLoad[j+1]) begin
        sR[j] <= sNx[j];
        cR[j] <= cNx[j];
        lR[j] <= lNx[j];
      end
    end
    for (int k = 0; k < WIDTH; k++) begin
      if (stageLoad[WIDTH+1+k]) begin
        psR[k] <= psNx[k];
        pcR[k] <= pcNx[k];
        hiR[k] <= hiNx[k];
        loR[k] <= loNx[k];
        cyR[k] <= cyNx[k];
      end
    end
  end

  assign coreProd = {hiR[WIDTH-1], loR[WIDTH-1]};

  if (PAD > 0) begin : gPad
    logic [PW-1:0] padR [PAD];
    always_ff @(posedge clk) begin
      if (stageLoad[CORE]) padR[0] <= coreProd;
      for (int p = 1; p < PAD; p++) begin
        if (stageLoad[CORE+p]) padR[p] <= padR[p-1];
      end
    end
    assign product = padR[PAD-1];
  end else begin : gNoPad
    assign product = coreProd;
  end

  // R1: the least significant product bit leaves the first row as a0 AND b0
  assert_first_bit_R1: assert property (@(posedge clk) disable iff (rst)
    stageLoad[1] |=> (lR[0][0] == $past(aR[0][0] & bR[0][0])));

  // R7: without a load into the last level the product does not move
  assert_product_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !stageLoad[LATENCY-1] |=> $stable(product));

endmodule

// File: rtl/signedArrayMult.sv
module signedArrayMult #(
  parameter int WIDTH   = 8,
  parameter int LATENCY = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);

  logic [LATENCY-1:0] stageLoad;

  samControl #(.LATENCY(LATENCY)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .stageLoad (stageLoad),
    .outValid  (outValid)
  );

  samDatapath #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_path (
    .clk       (clk),
    .rst       (rst),
    .stageLoad (stageLoad),
    .opA       (opA),
    .opB       (opB),
    .product   (product)
  );

  // R1: a flagged result is always a defined value
  assert_known_product_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !$isunknown(product));

endmodule

// File: tb/signedArrayMult_tb.sv
module signedArrayMult_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [7:0]  opA;
  logic [7:0]  opB;
  logic        outValid;
  logic [15:0] product;

  always #10 clk = ~clk;   // 20 ns period

  signedArrayMult u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .product  (product)
  );

  typedef struct {
    logic [15:0] exp;
    int          due;
    string       valTag;
    string       timeTag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  int seenValid = 0;
  logic [15:0] lastExp;

  always @(posedge clk) cycleCnt++;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] b,
                      input string vTag, input string tTag);
    item_t it;
    logic signed [15:0] e;
    @(negedge clk);
    opA = a;
    opB = b;
    inValid = 1'b1;
    e = $signed(a) * $signed(b);
    it.exp = e;
    it.due = cycleCnt + 17;   // sampled at next edge, shown 16 edges after it
    it.valTag = vTag;
    it.timeTag = tTag;
    sb.push_back(it);
    lastExp = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        seenValid++;
        if (sb.size() == 0) begin
          check(1'b0, "R4", "outValid with nothing outstanding", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.due == cycleCnt, it.timeTag, "result cycle", cycleCnt, it.due);
          check(product == it.exp, it.valTag, "product value",
                int'($signed(product)), int'($signed(it.exp)));
        end
      end else if (sb.size() > 0 && sb[0].due <= cycleCnt) begin
        check(1'b0, sb[0].timeTag, "result missing at cycle", cycleCnt, sb[0].due);
        void'(sb.pop_front());
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 120000);
    summary();
    $finish;
  end

  initial begin
    int vCount;
    rst = 1'b1;
    inValid = 1'b1;           // R5: this pair is present during reset and must be dropped
    opA = 8'd5;
    opB = 8'd7;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R5", "outValid in reset", outValid, 0);
    rst = 1'b0;
    inValid = 1'b0;
    vCount = 0;
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      if (outValid) vCount++;
    end
    check(vCount == 0, "R5", "results after reset with no input", vCount, 0);

    // R6 extremes with gaps between them (R4)
    seenValid = 0;
    send(8'h80, 8'h80, "R6", "R2");
    idle(1);
    send(8'h80, 8'h7F, "R6", "R2");
    send(8'h7F, 8'h80, "R6", "R4");
    idle(2);
    send(8'h7F, 8'h7F, "R6", "R2");
    send(8'hFF, 8'hFF, "R1", "R4");
    idle(3);
    send(8'h00, 8'h80, "R1", "R4");
    send(8'hFF, 8'h80, "R1", "R2");
    idle(24);
    check(seenValid == 7, "R4", "number of flagged results", seenValid, 7);
    check(sb.size() == 0, "R4", "results outstanding", sb.size(), 0);
    check(lastExp == 16'd128, "R6", "reference for -1 x -128", lastExp, 128);

    // R7: product holds while idle
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R7", "outValid while idle", outValid, 0);
      check(product == lastExp, "R7", "held product", product, lastExp);
    end

    // R1, R3: every pair, back-to-back
    seenValid = 0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        send(8'(a), 8'(b), "R1", "R3");
      end
    end
    idle(24);
    check(seenValid == 65536, "R3", "results from back-to-back sweep", seenValid, 65536);
    check(sb.size() == 0, "R3", "results outstanding", sb.size(), 0);

    // R5: reset while results are in flight
    for (int i = 0; i < 5; i++) send(8'(i + 3), 8'hF0, "R1", "R2");
    @(negedge clk);
    inValid = 1'b1;
    rst = 1'b1;
    sb.delete();
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R5", "outValid in mid-stream reset", outValid, 0);
    rst = 1'b0;
    inValid = 1'b0;
    vCount = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (outValid) vCount++;
    end
    check(vCount == 0, "R5", "flushed results reappearing", vCount, 0);

    // R2 after reset: the pipeline still works
    send(8'h80, 8'h80, "R6", "R2");
    idle(20);
    check(sb.size() == 0, "R2", "result after reset outstanding", sb.size(), 0);
    check(product == 16'h4000, "R6", "-128 x -128", product, 16'h4000);

    summary();
    $finish;
  end

endmodule